// File: doc/BRIEF.md
# Multithreaded Skid Buffer with Sequence Squash

This block is the input buffer of a pipeline stage shared by several hardware threads. Every entry carries a thread identifier and a sequence number. Entries wait in a separate first-in-first-out queue for each thread. All queues draw from one pool whose size equals the stage width. Each cycle the block takes up to a width's worth of entries from the previous stage. It hands buffered entries, in order, to the next stage as far as the downstream free space allows.

Each thread can be squashed at a sequence number. Buffered and arriving entries of that thread that are younger than the squash point are removed, and older ones are kept. An arriving entry that finds the pool full is not dropped. It is returned on an overflow lane, and an unblock indication tells the upstream stage to put it back at the front of its own buffer. Sequence numbers within one thread are assumed to increase in arrival order and do not wrap.

Top module: `mt_skid_buf`

## Requirements
- R1: Out of reset, `free_slots` equals W, every `thr_empty` bit is 1, and no issue, overflow or unblock lane is active. At all times, `free_slots` equals W minus the total number of entries held, and the total never exceeds W.
- R2: An arriving lane whose `in_kill` bit is set is discarded. It takes no room, and it does not count toward the overflow limit.
- R3: Arriving lanes are taken in lane order while held entries (after any squash) plus entries accepted this cycle are fewer than W. Every further surviving lane is echoed on the same `ovf_*` lane in that cycle, and `up_unblock` is raised.
- R4: When `sq_vld[t]` is high with point S, every buffered entry of thread t whose sequence number is greater than S is removed before the issue pass of that cycle. Entries at or below S remain.
- R5: In a squash cycle, an arriving entry of the squashed thread with a sequence number above S is dropped. It is neither buffered nor overflowed.
- R6: In one cycle, the number of issued entries is at most min(W, `dn_room`). Issued entries occupy the output lanes from lane 0 upward with no gaps.
- R7: Within a thread, entries issue in arrival order. Threads are served in turn starting from a round-robin pointer. The pointer is 0 after reset and advances by one in every cycle that issues anything. A thread is drained as far as the limit allows before the next thread is served.
- R8: `thr_empty[t]` is 1 exactly when thread t holds no entries. `backlog` is 1 in a cycle when entries remain in the buffer after that cycle's issue pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | W | Arriving lane valid |
| in_kill | input | W | Arriving lane already squashed |
| in_tid | input | W*TW | Thread of each arriving lane |
| in_seq | input | W*SW | Sequence number of each arriving lane |
| sq_vld | input | T | Squash request per thread |
| sq_seq | input | T*SW | Squash point per thread |
| dn_room | input | CW | Free entries downstream this cycle |
| out_vld | output | W | Issued lane valid |
| out_tid | output | W*TW | Thread of each issued lane |
| out_seq | output | W*SW | Sequence number of each issued lane |
| ovf_vld | output | W | Arriving lane returned upstream |
| ovf_tid | output | W*TW | Thread of each returned lane |
| ovf_seq | output | W*SW | Sequence number of each returned lane |
| up_unblock | output | 1 | Upstream must hold returned entries and unblock |
| free_slots | output | CW | Unused entries in the shared pool |
| thr_empty | output | T | Per-thread queue empty |
| backlog | output | 1 | Entries left after this cycle's issue pass |

## Verification
The bench builds the block with two threads, a width of four and eight-bit sequence numbers. Four entries fill the pool with a single burst of arrivals, so one more cycle of arrivals reaches the overflow path. Two threads are enough to watch the round-robin pointer alternate and to show that a squash of one thread leaves the other untouched. A downstream room from zero to above the width exercises both the room limit and the width limit on issue.

// File: rtl/mt_skid_buf.sv
module mt_skid_buf #(
  parameter int T  = 2,
  parameter int W  = 4,
  parameter int SW = 8,
  localparam int TW = (T > 1) ? $clog2(T) : 1,
  localparam int CW = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    in_vld,
  input  logic [W-1:0]    in_kill,
  input  logic [W*TW-1:0] in_tid,
  input  logic [W*SW-1:0] in_seq,
  input  logic [T-1:0]    sq_vld,
  input  logic [T*SW-1:0] sq_seq,
  input  logic [CW-1:0]   dn_room,
  output logic [W-1:0]    out_vld,
  output logic [W*TW-1:0] out_tid,
  output logic [W*SW-1:0] out_seq,
  output logic [W-1:0]    ovf_vld,
  output logic [W*TW-1:0] ovf_tid,
  output logic [W*SW-1:0] ovf_seq,
  output logic            up_unblock,
  output logic [CW-1:0]   free_slots,
  output logic [T-1:0]    thr_empty,
  output logic            backlog
);

  logic [SW-1:0] q   [T][W];
  logic [SW-1:0] nq  [T][W];
  logic [CW-1:0] cnt [T];
  logic [CW-1:0] ncnt_q [T];
  logic [TW-1:0] rr, rr_nx;

  int cs [T];
  int iss [T];
  int ncnt [T];
  int held, nout, lim, acc, tt, tid, idx, total_q;
  logic [SW-1:0] s;
  logic drop;

  always_comb begin
    held = 0;
    for (int t = 0; t < T; t++) begin
      cs[t] = 0;
      for (int j = 0; j < W; j++)
        if (j < int'(cnt[t]) && cs[t] == j &&
            (!sq_vld[t] || q[t][j] <= sq_seq[t*SW +: SW]))
          cs[t] = cs[t] + 1;
      held = held + cs[t];
    end

    lim = (int'(dn_room) < W) ? int'(dn_room) : W;
    nout = 0;
    out_vld = '0;
    out_tid = '0;
    out_seq = '0;
    for (int t = 0; t < T; t++) iss[t] = 0;
    for (int k = 0; k < T; k++) begin
      tt = (int'(rr) + k) % T;
      for (int j = 0; j < W; j++)
        if (j < cs[tt] && nout < lim) begin
          out_vld[nout] = 1'b1;
          out_tid[nout*TW +: TW] = TW'(tt);
          out_seq[nout*SW +: SW] = q[tt][j];
          iss[tt] = iss[tt] + 1;
          nout = nout + 1;
        end
    end
    backlog = (held - nout) > 0;
    rr_nx = (nout > 0) ? TW'((int'(rr) + 1) % T) : rr;

    for (int t = 0; t < T; t++) begin
      for (int j = 0; j < W; j++) begin
        idx = j + iss[t];
        nq[t][j] = (idx < W) ? q[t][idx] : '0;
      end
      ncnt[t] = cs[t] - iss[t];
    end

    acc = 0;
    ovf_vld = '0;
    ovf_tid = '0;
    ovf_seq = '0;
    up_unblock = 1'b0;
    for (int i = 0; i < W; i++) begin
      tid = int'(in_tid[i*TW +: TW]);
      s = in_seq[i*SW +: SW];
      drop = in_kill[i];
      if (tid < T && sq_vld[tid] && s > sq_seq[tid*SW +: SW]) drop = 1'b1;
      if (in_vld[i] && !drop && tid < T) begin
        if (held + acc < W) begin
          idx = ncnt[tid];
          if (idx < W) nq[tid][idx] = s;
          ncnt[tid] = ncnt[tid] + 1;
          acc = acc + 1;
        end else begin
          ovf_vld[i] = 1'b1;
          ovf_tid[i*TW +: TW] = in_tid[i*TW +: TW];
          ovf_seq[i*SW +: SW] = s;
          up_unblock = 1'b1;
        end
      end
    end
    for (int t = 0; t < T; t++) ncnt_q[t] = CW'(ncnt[t]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rr <= '0;
      for (int t = 0; t < T; t++) begin
        cnt[t] <= '0;
        for (int j = 0; j < W; j++) q[t][j] <= '0;
      end
    end else begin
      rr <= rr_nx;
      for (int t = 0; t < T; t++) begin
        cnt[t] <= ncnt_q[t];
        for (int j = 0; j < W; j++) q[t][j] <= nq[t][j];
      end
    end
  end

  always_comb begin
    total_q = 0;
    for (int t = 0; t < T; t++) begin
      total_q = total_q + int'(cnt[t]);
      thr_empty[t] = (cnt[t] == '0);
    end
    free_slots = CW'(W - total_q);
  end

endmodule

module mt_skid_buf_chk #(
  parameter int T  = 2,
  parameter int W  = 4,
  localparam int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] dn_room,
  input logic [W-1:0]  out_vld,
  input logic [W-1:0]  ovf_vld,
  input logic          up_unblock,
  input logic [CW-1:0] free_slots,
  input logic [T-1:0]  thr_empty,
  input logic          backlog
);
  logic [W:0] ov_inc;
  assign ov_inc = {1'b0, out_vld} + 1'b1;

  assert_pool_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_slots) <= W);
  assert_issue_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(out_vld) <= int'(dn_room));
  assert_issue_packed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_inc & {1'b0, out_vld}) == '0);
  assert_ovf_unblock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|ovf_vld) |-> up_unblock);
  assert_no_ovf_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(free_slots) == W) |-> !up_unblock);
  assert_empty_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&thr_empty) == (int'(free_slots) == W));
  assert_empty_no_backlog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&thr_empty) |-> !backlog);
endmodule

bind mt_skid_buf mt_skid_buf_chk #(.T(T), .W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .dn_room(dn_room), .out_vld(out_vld),
  .ovf_vld(ovf_vld), .up_unblock(up_unblock), .free_slots(free_slots),
  .thr_empty(thr_empty), .backlog(backlog)
);

// File: tb/mt_skid_buf_tb.sv
module mt_skid_buf_tb_top;
  localparam int T = 2, W = 4, SW = 8, TW = 1, CW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] in_vld, in_kill;
  logic [W*TW-1:0] in_tid;
  logic [W*SW-1:0] in_seq;
  logic [T-1:0] sq_vld;
  logic [T*SW-1:0] sq_seq;
  logic [CW-1:0] dn_room;
  logic [W-1:0] out_vld, ovf_vld;
  logic [W*TW-1:0] out_tid, ovf_tid;
  logic [W*SW-1:0] out_seq, ovf_seq;
  logic up_unblock, backlog;
  logic [CW-1:0] free_slots;
  logic [T-1:0] thr_empty;

  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  mt_skid_buf #(.T(T), .W(W), .SW(SW)) dut_i (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      fails++;
      $display("FAIL watchdog: act=%0d exp<=5000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clr();
    in_vld = '0; in_kill = '0; in_tid = '0; in_seq = '0;
    sq_vld = '0; sq_seq = '0;
  endtask

  task automatic put(int lane, int tid, int seq, bit kill);
    in_vld[lane] = 1'b1;
    in_kill[lane] = kill;
    in_tid[lane*TW +: TW] = TW'(tid);
    in_seq[lane*SW +: SW] = SW'(seq);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    clr();
    #1;
  endtask

  task automatic do_reset();
    clr();
    dn_room = '0;
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 free", int'(free_slots), 4);
    chk("R1 empty", int'(thr_empty), 3);
    chk("R1 out", int'(out_vld), 0);
    chk("R1 unblock", int'(up_unblock), 0);
  endtask

  task automatic t_fill_drain();
    do_reset();
    put(0, 0, 1, 0); put(1, 0, 2, 0);
    #1 chk("R3 no ovf", int'(ovf_vld), 0);
    tick();
    chk("R1 free after 2", int'(free_slots), 2);
    chk("R8 empty t0 busy", int'(thr_empty), 2);
    chk("R8 backlog", int'(backlog), 1);
    dn_room = 1; #1;
    chk("R6 one lane", int'(out_vld), 1);
    chk("R7 first seq", int'(out_seq[7:0]), 1);
    tick();
    chk("R1 free after issue", int'(free_slots), 3);
    dn_room = 4; #1;
    chk("R7 second seq", int'(out_seq[7:0]), 2);
    chk("R8 no backlog", int'(backlog), 0);
    tick();
    dn_room = 0; #1;
    chk("R8 all empty", int'(thr_empty), 3);
  endtask

  task automatic t_overflow_squash();
    do_reset();
    for (int i = 0; i < 4; i++) put(i, 1, 10 + i, 0);
    #1 chk("R3 unblock low", int'(up_unblock), 0);
    tick();
    chk("R1 full", int'(free_slots), 0);
    put(0, 0, 5, 0); put(2, 0, 6, 0);
    #1;
    chk("R3 ovf lanes", int'(ovf_vld), 5);
    chk("R3 ovf seq", int'(ovf_seq[23:16]), 6);
    chk("R3 unblock", int'(up_unblock), 1);
    tick();
    chk("R3 t0 still empty", int'(thr_empty), 1);
    sq_vld[1] = 1'b1; sq_seq[15:8] = 8'd11; dn_room = 4;
    put(0, 1, 12, 0); put(1, 0, 3, 0);
    #1;
    chk("R4 out lanes", int'(out_vld), 3);
    chk("R4 kept 10", int'(out_seq[7:0]), 10);
    chk("R4 kept 11", int'(out_seq[15:8]), 11);
    chk("R5 young dropped", int'(ovf_vld), 0);
    tick();
    chk("R5 free", int'(free_slots), 3);
    chk("R4 t1 empty", int'(thr_empty), 2);
    dn_room = 4; #1;
    chk("R5 t0 entry", int'(out_seq[7:0]), 3);
    chk("R5 t0 tid", int'(out_tid[0]), 0);
    tick();
  endtask

  task automatic t_kill();
    do_reset();
    put(0, 0, 1, 0); put(1, 0, 2, 0); put(2, 0, 3, 0);
    tick();
    put(0, 0, 4, 1); put(1, 0, 5, 0);
    #1 chk("R2 no ovf", int'(ovf_vld), 0);
    tick();
    chk("R2 full", int'(free_slots), 0);
    dn_room = 4; #1;
    chk("R2 lanes", int'(out_vld), 15);
    chk("R2 last seq", int'(out_seq[31:24]), 5);
    tick();
  endtask

  task automatic t_rr();
    do_reset();
    put(0, 0, 1, 0); put(1, 0, 2, 0); put(2, 1, 50, 0); put(3, 1, 51, 0);
    tick();
    dn_room = 1; #1;
    chk("R7 rr0 seq", int'(out_seq[7:0]), 1);
    tick(); dn_room = 1; #1;
    chk("R7 rr1 seq", int'(out_seq[7:0]), 50);
    tick(); dn_room = 1; #1;
    chk("R7 rr2 seq", int'(out_seq[7:0]), 2);
    tick(); dn_room = 1; #1;
    chk("R7 rr3 seq", int'(out_seq[7:0]), 51);
    tick();
    do_reset();
    put(0, 0, 1, 0); put(1, 0, 2, 0); put(2, 1, 50, 0); put(3, 1, 51, 0);
    tick();
    dn_room = 3; #1;
    chk("R6 three lanes", int'(out_vld), 7);
    chk("R7 drain t0 then t1", int'(out_seq[23:16]), 50);
    chk("R8 backlog left", int'(backlog), 1);
    tick();
    dn_room = 7; #1;
    chk("R6 width cap", int'(out_vld), 1);
    chk("R7 rr moved", int'(out_seq[7:0]), 51);
    tick();
  endtask

  initial begin
    clr();
    dn_room = '0;
    t_reset();
    t_fill_drain();
    t_overflow_squash();
    t_kill();
    t_rr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule